// File: doc/BRIEF.md
# Vector Multiply-Add Hazard and Flag Retirement Queue

This block tracks results of the vector multiply-add pipe that are still in flight. Every instruction bundle whose upper half, lower half or both use the multiply-add pipe claims one slot of a small circular queue. A slot records the destination register and component mask of each half, the union of the flag registers the bundle writes, the MAC, status and clip values captured at issue, and a countdown to completion. An issue stage asks the block whether a vector source operand (register plus component mask) must stall, and for how many cycles.

Slots leave the queue strictly in issue order. When the oldest slot completes it is retired and its captured values are merged into the architectural MAC, status and clip flag registers. Two rules govern the status merge: one for instructions that set the status flag explicitly and one for ordinary arithmetic, which keeps the sticky copy. A drain request retires everything at once, in order, whether or not it is complete, and the block reports how many cycles the youngest slot would still have needed.

Top module: `vmac_flag_queue`

## Requirements
- R1: After reset the occupancy is 0, the MAC, status and clip flag outputs are 0, no source query stalls and `drain_wait` is 0.
- R2: A bundle with `bnd_up_en` or `bnd_lo_en` high claims exactly one slot (occupancy rises by one at the next edge); a bundle with both low claims nothing.
- R3: A slot issued in cycle t is complete in cycle t+4 (LATENCY). A matching source query in cycles t+1, t+2, t+3 reports stall with `src_wait` of 3, 2, 1; in cycle t+4 it reports no stall and a wait of 0.
- R4: A query matches a slot when its register equals the upper or the lower destination of that slot and its mask shares at least one component bit with that half's mask; a different register, disjoint mask or `src_en` low gives no stall.
- R5: Each query port is judged independently, and when several slots match, `src_wait` is the largest remaining count among them.
- R6: Slots retire in issue order, at most one per edge without a drain: a slot issued in cycle t updates the flag outputs in cycle t+5, and flags do not change in a cycle where nothing retired.
- R7: On retirement, bit 1 of the slot's flag-write mask (clip) loads the captured clip value into `clip_flag`; otherwise `clip_flag` keeps its value.
- R8: With bit 0 of the flag-write mask (status) set, the new status is (old AND 0x030) OR (captured AND 0xFC0) OR (captured AND 0x00F).
- R9: With bit 0 clear, the new status is (old AND 0xFF0) OR (captured AND 0x00F) OR ((captured AND 0x00F) shifted left by 6); in both cases `mac_flag` takes the captured MAC value.
- R10: A slot's flag-write mask is the OR of the masks of the enabled halves, and a disabled half stores no destination (its register never matches a query).
- R11: `flush_all` retires every occupied slot in order at one edge, applying R7, R8 and R9 slot by slot; a bundle issued in the same cycle is kept as the only slot; `drain_wait` shows the largest remaining count of occupied slots.
- R12: With four slots occupied, a bundle issued in the cycle the oldest slot retires is accepted and occupancy stays at four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bnd_up_en | input | 1 | Upper half of the bundle uses the multiply-add pipe |
| bnd_up_reg | input | REG_W | Upper half destination register |
| bnd_up_mask | input | MASK_W | Upper half destination component mask |
| bnd_up_fw | input | 2 | Upper half flag-write mask (bit 0 status, bit 1 clip) |
| bnd_lo_en | input | 1 | Lower half of the bundle uses the multiply-add pipe |
| bnd_lo_reg | input | REG_W | Lower half destination register |
| bnd_lo_mask | input | MASK_W | Lower half destination component mask |
| bnd_lo_fw | input | 2 | Lower half flag-write mask (bit 0 status, bit 1 clip) |
| bnd_mac | input | MAC_W | MAC flag value captured at issue |
| bnd_stat | input | 12 | Status flag value captured at issue |
| bnd_clip | input | CLIP_W | Clip flag value captured at issue |
| src_en | input | NUM_SRC | Per-port query valid |
| src_reg | input | NUM_SRC*REG_W | Per-port source register, port p in slice p |
| src_mask | input | NUM_SRC*MASK_W | Per-port source component mask |
| src_stall | output | NUM_SRC | Per-port stall indication |
| src_wait | output | NUM_SRC*LAT_W | Per-port cycles until the operand is ready |
| flush_all | input | 1 | Retire all slots at the next edge |
| drain_wait | output | LAT_W | Largest remaining count of occupied slots |
| occupancy | output | CNT_W | Number of occupied slots |
| mac_flag | output | MAC_W | Architectural MAC flag register |
| status_flag | output | 12 | Architectural status flag register |
| clip_flag | output | CLIP_W | Architectural clip flag register |

## Verification
Two things can land on one edge: the oldest slot retiring while a new bundle claims a slot, and a drain while a bundle is issued. The first is provoked by five back-to-back bundles, so the fifth arrives with four slots held and the oldest just complete; occupancy must hold at four and the retired flags must match the scoreboard at the expected cycle. The second is provoked by raising `flush_all` in the same cycle as a new bundle behind three unfinished slots; the flags must equal the in-order merge of all three, and only the new slot must remain and still stall its own register.

// File: rtl/vmq_pkg.sv
package vmq_pkg;

   localparam int STAT_W  = 12;
   localparam int FW_W    = 2;
   localparam int FW_STAT = 0;
   localparam int FW_CLIP = 1;

   localparam logic [STAT_W-1:0] SET_KEEP  = 12'h030;
   localparam logic [STAT_W-1:0] SET_TAKE  = 12'hFC0;
   localparam logic [STAT_W-1:0] ORD_KEEP  = 12'hFF0;
   localparam logic [STAT_W-1:0] LIVE_BITS = 12'h00F;
   localparam int                STICKY_SH = 6;

   // Status merge applied when one slot retires.
   function automatic logic [STAT_W-1:0] merge_status(
      input logic [STAT_W-1:0] cur,
      input logic [STAT_W-1:0] cap,
      input logic              explicit_set
   );
      logic [STAT_W-1:0] live;
      live = cap & LIVE_BITS;
      if (explicit_set)
         return (cur & SET_KEEP) | (cap & SET_TAKE) | live;
      else
         return (cur & ORD_KEEP) | live | (live << STICKY_SH);
   endfunction

endpackage

// File: rtl/vmq_slots.sv
module vmq_slots #(
   parameter int DEPTH   = 4,
   parameter int REG_W   = 5,
   parameter int MASK_W  = 4,
   parameter int MAC_W   = 16,
   parameter int CLIP_W  = 24,
   parameter int LATENCY = 4,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int LAT_W  = $clog2(LATENCY + 1),
   localparam int STAT_W = vmq_pkg::STAT_W,
   localparam int FW_W   = vmq_pkg::FW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic              up_en,
   input  logic [REG_W-1:0]  up_reg,
   input  logic [MASK_W-1:0] up_mask,
   input  logic [FW_W-1:0]   up_fw,
   input  logic              lo_en,
   input  logic [REG_W-1:0]  lo_reg,
   input  logic [MASK_W-1:0] lo_mask,
   input  logic [FW_W-1:0]   lo_fw,
   input  logic [MAC_W-1:0]  cap_mac,
   input  logic [STAT_W-1:0] cap_stat,
   input  logic [CLIP_W-1:0] cap_clip,
   output logic [REG_W-1:0]  e_up_reg  [DEPTH],
   output logic [MASK_W-1:0] e_up_mask [DEPTH],
   output logic [REG_W-1:0]  e_lo_reg  [DEPTH],
   output logic [MASK_W-1:0] e_lo_mask [DEPTH],
   output logic [FW_W-1:0]   e_fw      [DEPTH],
   output logic [MAC_W-1:0]  e_mac     [DEPTH],
   output logic [STAT_W-1:0] e_stat    [DEPTH],
   output logic [CLIP_W-1:0] e_clip    [DEPTH],
   output logic [LAT_W-1:0]  e_rem     [DEPTH]
);

   localparam logic [LAT_W-1:0] REM_LOAD = LAT_W'(LATENCY - 1);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_ptr == PTR_W'(g));

      // Claiming a slot clears both halves, then fills the enabled ones.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_up_reg[g]  <= '0;
            e_up_mask[g] <= '0;
            e_lo_reg[g]  <= '0;
            e_lo_mask[g] <= '0;
            e_fw[g]      <= '0;
            e_mac[g]     <= '0;
            e_stat[g]    <= '0;
            e_clip[g]    <= '0;
            e_rem[g]     <= '0;
         end else if (hit) begin
            e_up_reg[g]  <= up_en ? up_reg  : '0;
            e_up_mask[g] <= up_en ? up_mask : '0;
            e_lo_reg[g]  <= lo_en ? lo_reg  : '0;
            e_lo_mask[g] <= lo_en ? lo_mask : '0;
            e_fw[g]      <= (up_en ? up_fw : '0) | (lo_en ? lo_fw : '0);
            e_mac[g]     <= cap_mac;
            e_stat[g]    <= cap_stat;
            e_clip[g]    <= cap_clip;
            e_rem[g]     <= REM_LOAD;
         end else if (e_rem[g] != '0) begin
            e_rem[g]     <= e_rem[g] - 1'b1;
         end
      end
   end

endmodule

// File: rtl/vmq_hazard.sv
module vmq_hazard #(
   parameter int DEPTH   = 4,
   parameter int REG_W   = 5,
   parameter int MASK_W  = 4,
   parameter int LATENCY = 4,
   localparam int LAT_W  = $clog2(LATENCY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEPTH-1:0]  occ,
   input  logic [REG_W-1:0]  e_up_reg  [DEPTH],
   input  logic [MASK_W-1:0] e_up_mask [DEPTH],
   input  logic [REG_W-1:0]  e_lo_reg  [DEPTH],
   input  logic [MASK_W-1:0] e_lo_mask [DEPTH],
   input  logic [LAT_W-1:0]  e_rem     [DEPTH],
   input  logic              q_en,
   input  logic [REG_W-1:0]  q_reg,
   input  logic [MASK_W-1:0] q_mask,
   output logic              q_stall,
   output logic [LAT_W-1:0]  q_wait
);

   logic [DEPTH-1:0] hit;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         hit[i] = q_en && occ[i] && (e_rem[i] != '0) &&
                  (((e_up_reg[i] == q_reg) && |(e_up_mask[i] & q_mask)) ||
                   ((e_lo_reg[i] == q_reg) && |(e_lo_mask[i] & q_mask)));
      end
   end

   always_comb begin
      q_wait = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (hit[i] && (e_rem[i] > q_wait)) q_wait = e_rem[i];
      end
   end

   assign q_stall = |hit;

   // R3: a stall always carries a nonzero wait, and no stall means no wait
   p_wait_agrees_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_stall == (q_wait != '0));

endmodule

// File: rtl/vmq_retire.sv
module vmq_retire #(
   parameter int DEPTH   = 4,
   parameter int MAC_W   = 16,
   parameter int CLIP_W  = 24,
   parameter int LATENCY = 4,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int LAT_W  = $clog2(LATENCY + 1),
   localparam int STAT_W = vmq_pkg::STAT_W,
   localparam int FW_W   = vmq_pkg::FW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic [CNT_W-1:0]  count,
   input  logic [FW_W-1:0]   e_fw   [DEPTH],
   input  logic [MAC_W-1:0]  e_mac  [DEPTH],
   input  logic [STAT_W-1:0] e_stat [DEPTH],
   input  logic [CLIP_W-1:0] e_clip [DEPTH],
   input  logic [LAT_W-1:0]  e_rem  [DEPTH],
   output logic [CNT_W-1:0]  n_ret,
   output logic [MAC_W-1:0]  mac_q,
   output logic [STAT_W-1:0] stat_q,
   output logic [CLIP_W-1:0] clip_q
);

   logic [MAC_W-1:0]  nx_mac;
   logic [STAT_W-1:0] nx_stat;
   logic [CLIP_W-1:0] nx_clip;

   // In-order walk from the oldest slot; the first slot not taken ends it.
   always_comb begin
      logic [PTR_W-1:0] idx;
      logic             go;
      nx_mac  = mac_q;
      nx_stat = stat_q;
      nx_clip = clip_q;
      n_ret   = '0;
      go      = 1'b1;
      idx     = rd_ptr;
      for (int i = 0; i < DEPTH; i++) begin
         idx = rd_ptr + PTR_W'(i);
         if (go && (CNT_W'(i) < count) &&
             (flush || ((i == 0) && (e_rem[idx] == '0)))) begin
            if (e_fw[idx][vmq_pkg::FW_CLIP]) nx_clip = e_clip[idx];
            nx_stat = vmq_pkg::merge_status(nx_stat, e_stat[idx],
                                            e_fw[idx][vmq_pkg::FW_STAT]);
            nx_mac  = e_mac[idx];
            n_ret   = n_ret + 1'b1;
         end else begin
            go = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mac_q  <= '0;
         stat_q <= '0;
         clip_q <= '0;
      end else begin
         mac_q  <= nx_mac;
         stat_q <= nx_stat;
         clip_q <= nx_clip;
      end
   end

   // R6: without a drain at most one slot leaves per edge
   p_single_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |-> (n_ret <= CNT_W'(1)));

   // R6: flag registers only move on an edge that retired something
   p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (n_ret == '0) |=> ($stable(mac_q) && $stable(stat_q) && $stable(clip_q)));

endmodule

// File: rtl/vmac_flag_queue.sv
module vmac_flag_queue #(
   parameter int DEPTH   = 4,
   parameter int REG_W   = 5,
   parameter int MASK_W  = 4,
   parameter int MAC_W   = 16,
   parameter int CLIP_W  = 24,
   parameter int LATENCY = 4,
   parameter int NUM_SRC = 2,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int LAT_W  = $clog2(LATENCY + 1),
   localparam int STAT_W = vmq_pkg::STAT_W,
   localparam int FW_W   = vmq_pkg::FW_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bnd_up_en,
   input  logic [REG_W-1:0]          bnd_up_reg,
   input  logic [MASK_W-1:0]         bnd_up_mask,
   input  logic [FW_W-1:0]           bnd_up_fw,
   input  logic                      bnd_lo_en,
   input  logic [REG_W-1:0]          bnd_lo_reg,
   input  logic [MASK_W-1:0]         bnd_lo_mask,
   input  logic [FW_W-1:0]           bnd_lo_fw,
   input  logic [MAC_W-1:0]          bnd_mac,
   input  logic [STAT_W-1:0]         bnd_stat,
   input  logic [CLIP_W-1:0]         bnd_clip,
   input  logic [NUM_SRC-1:0]        src_en,
   input  logic [NUM_SRC*REG_W-1:0]  src_reg,
   input  logic [NUM_SRC*MASK_W-1:0] src_mask,
   output logic [NUM_SRC-1:0]        src_stall,
   output logic [NUM_SRC*LAT_W-1:0]  src_wait,
   input  logic                      flush_all,
   output logic [LAT_W-1:0]          drain_wait,
   output logic [CNT_W-1:0]          occupancy,
   output logic [MAC_W-1:0]          mac_flag,
   output logic [STAT_W-1:0]         status_flag,
   output logic [CLIP_W-1:0]         clip_flag
);

   // Elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
      $error("vmac_flag_queue: DEPTH must be a power of two of at least 2");
   if (LATENCY < 1 || LATENCY > DEPTH)
      $error("vmac_flag_queue: LATENCY must lie in 1..DEPTH");
   if (NUM_SRC < 1)
      $error("vmac_flag_queue: NUM_SRC must be at least 1");

   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  count, n_ret;
   logic              push;
   logic [DEPTH-1:0]  occ;

   logic [REG_W-1:0]  e_up_reg  [DEPTH];
   logic [MASK_W-1:0] e_up_mask [DEPTH];
   logic [REG_W-1:0]  e_lo_reg  [DEPTH];
   logic [MASK_W-1:0] e_lo_mask [DEPTH];
   logic [FW_W-1:0]   e_fw      [DEPTH];
   logic [MAC_W-1:0]  e_mac     [DEPTH];
   logic [STAT_W-1:0] e_stat    [DEPTH];
   logic [CLIP_W-1:0] e_clip    [DEPTH];
   logic [LAT_W-1:0]  e_rem     [DEPTH];

   assign push      = bnd_up_en | bnd_lo_en;
   assign occupancy = count;

   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         logic [PTR_W-1:0] off;
         off    = PTR_W'(j) - rd_ptr;
         occ[j] = CNT_W'(off) < count;
      end
   end

   always_comb begin
      drain_wait = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (occ[j] && (e_rem[j] > drain_wait)) drain_wait = e_rem[j];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         rd_ptr <= rd_ptr + PTR_W'(n_ret);
         wr_ptr <= wr_ptr + PTR_W'(push);
         count  <= count - n_ret + CNT_W'(push);
      end
   end

   vmq_slots #(
      .DEPTH(DEPTH), .REG_W(REG_W), .MASK_W(MASK_W),
      .MAC_W(MAC_W), .CLIP_W(CLIP_W), .LATENCY(LATENCY)
   ) u_slots (
      .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_ptr(wr_ptr),
      .up_en(bnd_up_en), .up_reg(bnd_up_reg), .up_mask(bnd_up_mask), .up_fw(bnd_up_fw),
      .lo_en(bnd_lo_en), .lo_reg(bnd_lo_reg), .lo_mask(bnd_lo_mask), .lo_fw(bnd_lo_fw),
      .cap_mac(bnd_mac), .cap_stat(bnd_stat), .cap_clip(bnd_clip),
      .e_up_reg(e_up_reg), .e_up_mask(e_up_mask), .e_lo_reg(e_lo_reg),
      .e_lo_mask(e_lo_mask), .e_fw(e_fw), .e_mac(e_mac), .e_stat(e_stat),
      .e_clip(e_clip), .e_rem(e_rem)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      vmq_hazard #(
         .DEPTH(DEPTH), .REG_W(REG_W), .MASK_W(MASK_W), .LATENCY(LATENCY)
      ) u_hz (
         .clk(clk), .rst_n(rst_n), .occ(occ),
         .e_up_reg(e_up_reg), .e_up_mask(e_up_mask),
         .e_lo_reg(e_lo_reg), .e_lo_mask(e_lo_mask), .e_rem(e_rem),
         .q_en(src_en[s]),
         .q_reg(src_reg[s*REG_W +: REG_W]),
         .q_mask(src_mask[s*MASK_W +: MASK_W]),
         .q_stall(src_stall[s]),
         .q_wait(src_wait[s*LAT_W +: LAT_W])
      );
   end

   vmq_retire #(
      .DEPTH(DEPTH), .MAC_W(MAC_W), .CLIP_W(CLIP_W), .LATENCY(LATENCY)
   ) u_retire (
      .clk(clk), .rst_n(rst_n), .flush(flush_all), .rd_ptr(rd_ptr), .count(count),
      .e_fw(e_fw), .e_mac(e_mac), .e_stat(e_stat), .e_clip(e_clip), .e_rem(e_rem),
      .n_ret(n_ret), .mac_q(mac_flag), .stat_q(status_flag), .clip_q(clip_flag)
   );

   // R12: a full queue only takes a bundle on an edge that also retires
   p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH) && push) |-> (n_ret != '0));

   // R2: pointer distance and occupancy count stay consistent
   p_ptr_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      PTR_W'(wr_ptr - rd_ptr) == PTR_W'(count));

   // R11: after a drain only a bundle issued alongside it remains
   p_flush_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (count == CNT_W'($past(push))));

   // R3: no occupied slot can report more than LATENCY-1 cycles left
   p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      drain_wait <= LAT_W'(LATENCY - 1));

endmodule

// File: tb/vmac_flag_queue_bench.sv
`timescale 1ns/100ps
module vmac_flag_queue_bench;

   localparam int REG_W  = 5;
   localparam int MASK_W = 4;
   localparam int MAC_W  = 16;
   localparam int CLIP_W = 24;
   localparam int LAT_W  = 3;
   localparam int CNT_W  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              bnd_up_en = 0, bnd_lo_en = 0;
   logic [REG_W-1:0]  bnd_up_reg = '0, bnd_lo_reg = '0;
   logic [MASK_W-1:0] bnd_up_mask = '0, bnd_lo_mask = '0;
   logic [1:0]        bnd_up_fw = '0, bnd_lo_fw = '0;
   logic [MAC_W-1:0]  bnd_mac = '0;
   logic [11:0]       bnd_stat = '0;
   logic [CLIP_W-1:0] bnd_clip = '0;
   logic [1:0]        src_en = '0;
   logic [2*REG_W-1:0]  src_reg = '0;
   logic [2*MASK_W-1:0] src_mask = '0;
   logic [1:0]        src_stall;
   logic [2*LAT_W-1:0] src_wait;
   logic              flush_all = 0;
   logic [LAT_W-1:0]  drain_wait;
   logic [CNT_W-1:0]  occupancy;
   logic [MAC_W-1:0]  mac_flag;
   logic [11:0]       status_flag;
   logic [CLIP_W-1:0] clip_flag;

   vmac_flag_queue u_vmac_flag_queue (
      .clk(clk), .rst_n(rst_n),
      .bnd_up_en(bnd_up_en), .bnd_up_reg(bnd_up_reg), .bnd_up_mask(bnd_up_mask), .bnd_up_fw(bnd_up_fw),
      .bnd_lo_en(bnd_lo_en), .bnd_lo_reg(bnd_lo_reg), .bnd_lo_mask(bnd_lo_mask), .bnd_lo_fw(bnd_lo_fw),
      .bnd_mac(bnd_mac), .bnd_stat(bnd_stat), .bnd_clip(bnd_clip),
      .src_en(src_en), .src_reg(src_reg), .src_mask(src_mask),
      .src_stall(src_stall), .src_wait(src_wait),
      .flush_all(flush_all), .drain_wait(drain_wait), .occupancy(occupancy),
      .mac_flag(mac_flag), .status_flag(status_flag), .clip_flag(clip_flag)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [MAC_W-1:0]  mac;
      logic [11:0]       st;
      logic [CLIP_W-1:0] clip;
      int                due;
   } exp_t;
   exp_t sb[$];

   logic [MAC_W-1:0]  m_mac = '0;
   logic [11:0]       m_st = '0;
   logic [CLIP_W-1:0] m_clip = '0;

   // Reference merge written from R8 / R9
   function automatic logic [11:0] ref_status(logic [11:0] cur, logic [11:0] cap, logic setf);
      if (setf) return (cur & 12'h030) | (cap & 12'hFC0) | (cap & 12'h00F);
      return (cur & 12'hFF0) | (cap & 12'h00F) | ((cap & 12'h00F) << 6);
   endfunction

   task automatic check(logic ok, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", what, act, exp, cyc);
      end
   endtask

   // Monitor: pop every item due this cycle and compare the last one.
   always @(negedge clk) begin
      if (rst_n && sb.size() > 0 && sb[0].due == cyc) begin
         exp_t last;
         last = sb[0];
         while (sb.size() > 0 && sb[0].due == cyc) last = sb.pop_front();
         check(mac_flag == last.mac, "R9 mac_flag", mac_flag, last.mac);
         check(status_flag == last.st, "R8/R9 status_flag", status_flag, last.st);
         check(clip_flag == last.clip, "R7 clip_flag", clip_flag, last.clip);
      end
   end

   task automatic tick();
      @(negedge clk);
      bnd_up_en = 0; bnd_lo_en = 0; flush_all = 0;
   endtask

   // Driver: one bundle per call, expected retirement pushed to the scoreboard.
   task automatic bundle(logic ue, logic [REG_W-1:0] ur, logic [MASK_W-1:0] um, logic [1:0] uf,
                         logic le, logic [REG_W-1:0] lr, logic [MASK_W-1:0] lm, logic [1:0] lf,
                         logic [MAC_W-1:0] mac, logic [11:0] st, logic [CLIP_W-1:0] clip,
                         logic with_flush);
      logic [1:0] fw;
      exp_t e;
      @(negedge clk);
      bnd_up_en = ue; bnd_up_reg = ur; bnd_up_mask = um; bnd_up_fw = uf;
      bnd_lo_en = le; bnd_lo_reg = lr; bnd_lo_mask = lm; bnd_lo_fw = lf;
      bnd_mac = mac; bnd_stat = st; bnd_clip = clip;
      flush_all = with_flush;
      if (with_flush) begin
         foreach (sb[k]) if (sb[k].due > cyc + 1) sb[k].due = cyc + 1;
      end
      if (ue || le) begin
         fw = (ue ? uf : 2'b00) | (le ? lf : 2'b00);
         if (fw[1]) m_clip = clip;
         m_st  = ref_status(m_st, st, fw[0]);
         m_mac = mac;
         e.mac = m_mac; e.st = m_st; e.clip = m_clip; e.due = cyc + 5;
         sb.push_back(e);
      end
   endtask

   task automatic chk_src(int p, logic en, logic [REG_W-1:0] r, logic [MASK_W-1:0] m,
                          logic exp_stall, int exp_wait, string tag);
      src_en[p] = en;
      src_reg[p*REG_W +: REG_W] = r;
      src_mask[p*MASK_W +: MASK_W] = m;
      #1;
      check(src_stall[p] == exp_stall, {tag, " stall"}, src_stall[p], exp_stall);
      check(int'(src_wait[p*LAT_W +: LAT_W]) == exp_wait, {tag, " wait"},
            src_wait[p*LAT_W +: LAT_W], exp_wait);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(occupancy == 0, "R1 occupancy", occupancy, 0);
      check(mac_flag == 0 && status_flag == 0 && clip_flag == 0, "R1 flags",
            {mac_flag, status_flag}, 0);
      check(drain_wait == 0, "R1 drain_wait", drain_wait, 0);
      chk_src(0, 1, 5'd0, 4'hF, 0, 0, "R1 port0");
      chk_src(1, 1, 5'd0, 4'hF, 0, 0, "R1 port1");

      // Single upper-half slot: countdown and completion
      bundle(1, 5'd5, 4'b1000, 2'b00, 0, 5'd0, 4'h0, 2'b00, 16'h1234, 12'h005, 24'hAAAAAA, 0);
      tick();
      check(occupancy == 1, "R2 claim", occupancy, 1);
      chk_src(0, 1, 5'd5, 4'b1000, 1, 3, "R3 t+1");
      chk_src(1, 1, 5'd5, 4'b0100, 0, 0, "R4 disjoint mask");
      chk_src(1, 1, 5'd6, 4'b1000, 0, 0, "R4 other reg");
      tick();
      chk_src(0, 1, 5'd5, 4'b1000, 1, 2, "R3 t+2");
      tick();
      chk_src(0, 1, 5'd5, 4'b1100, 1, 1, "R3 t+3");
      tick();
      chk_src(0, 1, 5'd5, 4'b1000, 0, 0, "R3 complete");
      check(occupancy == 1, "R6 not yet retired", occupancy, 1);
      tick();
      check(occupancy == 0, "R6 retired", occupancy, 0);
      src_en = '0;

      // Both halves, OR of flag-write masks, lower match
      bundle(1, 5'd9, 4'b1111, 2'b01, 1, 5'd7, 4'b0011, 2'b10, 16'hBEEF, 12'h835, 24'h123456, 0);
      tick();
      chk_src(0, 1, 5'd9, 4'b0010, 1, 3, "R4 upper match");
      chk_src(1, 1, 5'd7, 4'b0001, 1, 3, "R4 lower match");
      chk_src(1, 1, 5'd7, 4'b0100, 0, 0, "R4 lower disjoint");
      chk_src(0, 0, 5'd9, 4'b1111, 0, 0, "R4 query disabled");
      bundle(0, 5'd9, 4'hF, 2'b11, 0, 5'd7, 4'hF, 2'b11, 16'hFFFF, 12'hFFF, 24'hFFFFFF, 0);
      tick();
      check(occupancy == 1, "R2 empty bundle", occupancy, 1);
      repeat (4) tick();
      src_en = '0;

      // Lower-only slot: disabled upper stores nothing (R10)
      bundle(0, 5'd2, 4'b1111, 2'b01, 1, 5'd4, 4'b1000, 2'b10, 16'h0F0F, 12'h3C9, 24'h00BEEF, 0);
      tick();
      chk_src(0, 1, 5'd2, 4'b1111, 0, 0, "R10 disabled half");
      chk_src(1, 1, 5'd4, 4'b1000, 1, 3, "R10 lower kept");
      repeat (5) tick();
      src_en = '0;

      // Burst of five: max wait, independent ports, full queue issue
      bundle(1, 5'd3, 4'b0001, 2'b00, 0, 5'd0, 4'h0, 2'b00, 16'h1111, 12'h00A, 24'h000001, 0);
      bundle(1, 5'd3, 4'b0001, 2'b01, 0, 5'd0, 4'h0, 2'b00, 16'h2222, 12'hA4C, 24'h000002, 0);
      bundle(1, 5'd3, 4'b0001, 2'b10, 0, 5'd0, 4'h0, 2'b00, 16'h3333, 12'h0F3, 24'h000003, 0);
      chk_src(0, 1, 5'd3, 4'b0001, 1, 3, "R5 max wait");
      chk_src(1, 1, 5'd8, 4'b0001, 0, 0, "R5 other port");
      bundle(0, 5'd0, 4'h0, 2'b00, 1, 5'd3, 4'b0010, 2'b11, 16'h4444, 12'h5C0, 24'h000004, 0);
      bundle(1, 5'd3, 4'b0001, 2'b01, 0, 5'd0, 4'h0, 2'b00, 16'h5555, 12'h13F, 24'h000005, 0);
      #1;
      check(occupancy == 4, "R12 full before issue", occupancy, 4);
      tick();
      check(occupancy == 4, "R12 issue with retire", occupancy, 4);
      repeat (6) tick();
      check(occupancy == 0, "R6 burst drained", occupancy, 0);
      src_en = '0;

      // Drain with a bundle in the same cycle
      bundle(1, 5'd10, 4'b0001, 2'b01, 0, 5'd0, 4'h0, 2'b00, 16'hA001, 12'hFC5, 24'h0A0A0A, 0);
      bundle(1, 5'd11, 4'b0001, 2'b00, 0, 5'd0, 4'h0, 2'b00, 16'hA002, 12'h006, 24'h0B0B0B, 0);
      bundle(0, 5'd0, 4'h0, 2'b00, 1, 5'd12, 4'b0100, 2'b10, 16'hA003, 12'h009, 24'h0C0C0C, 0);
      bundle(1, 5'd13, 4'b0010, 2'b00, 0, 5'd0, 4'h0, 2'b00, 16'hA004, 12'h003, 24'h0D0D0D, 1);
      #1;
      check(drain_wait == 3, "R11 drain_wait", drain_wait, 3);
      tick();
      check(occupancy == 1, "R11 drained", occupancy, 1);
      chk_src(0, 1, 5'd12, 4'b0100, 0, 0, "R11 flushed slot");
      chk_src(1, 1, 5'd13, 4'b0010, 1, 3, "R11 concurrent bundle");
      repeat (6) tick();
      src_en = '0;

      // Drain of an empty queue leaves flags alone
      bundle(0, 5'd0, 4'h0, 2'b00, 0, 5'd0, 4'h0, 2'b00, 16'h0, 12'h0, 24'h0, 1);
      tick();
      check(occupancy == 0, "R11 empty drain", occupancy, 0);
      check(mac_flag == m_mac, "R11 empty drain mac", mac_flag, m_mac);
      repeat (3) tick();
      check(sb.size() == 0, "R6 scoreboard empty", sb.size(), 0);

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule